// File: doc/BRIEF.md
# Ones'-Complement Accumulator With Overflow Bit

This block is the arithmetic core of a small sequential processor. It holds one 16-bit ones'-complement accumulator. Bit 16 is an uncorrected sign (UC) and bit 15 is the ordinary sign (SG). When the two differ, the value carries an overflow inside itself, so no separate sticky flag is needed. A sequencer raises `start` for one cycle with an operation code and an operand. The block then loads, negates, adds, subtracts, masks or stores.

On a store, the 16-bit value is folded into a 15-bit memory word. UC takes the place of SG. If the accumulator holds an overflow at that point, the store costs one more cycle. In that cycle the accumulator is replaced by +1 or -1, according to the true sign, and the block reports that the next instruction must be skipped.

The sequencer samples the `done`, `skip` and `extraCycle` pulses to advance its program counter.

Top module: `oc_accum_top`

## Requirements
- R1: After reset, `acc`, `storeVal`, `done`, `skip` and `extraCycle` are all zero.
- R2: The load operation (code 0) sets `acc` to the operand. When `opWide` is 0, the operand is taken as a 15-bit word (bits 14:0) and sign-extended by copying bit 14 into bit 15. When `opWide` is 1, all 16 bits are used unchanged.
- R3: The negated load (code 1) sets `acc` to the bitwise inversion of the extended operand. Negating +0 gives -0 (177777 octal).
- R4: Add (code 2) forms the 16-bit sum of `acc` and the extended operand. A carry out of bit 16 is fed back into the least significant bit. Adding any x to its inverse gives 177777.
- R5: `ovf` is high exactly when `acc` bit 16 differs from bit 15. For example, 037777 plus 1 yields 040000 with `ovf` high, which is a positive overflow.
- R6: Subtract (code 3) gives the same result as add with the extended operand inverted first.
- R7: Mask (code 4) sets `acc` to the bitwise AND of `acc` and the extended operand.
- R8: Store (code 5) loads `storeVal` with bit 16 of `acc` in bit 15 and `acc` bits 14:1 below it, so SG is dropped. With no overflow present, `acc` is unchanged, and `done` pulses with `skip` and `extraCycle` low.
- R9: Store with overflow present takes one extra cycle. At its end, `acc` becomes 000001 if UC is 0, or 177776 if UC is 1. `done`, `skip` and `extraCycle` pulse together.
- R10: Overflow skip (code 6) leaves `acc` unchanged. `done` pulses, `skip` equals the overflow state, and `extraCycle` stays low.
- R11: Each of `done`, `skip` and `extraCycle` is high for exactly one cycle per operation. A `start` in the extra store cycle is ignored. Code 7 only pulses `done`.
- R12: Every result is visible on the outputs in the cycle after the edge that samples `start`. The exception is the store with overflow, whose replacement value and pulses appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe, one cycle |
| opCode | input | 3 | Operation code (0 to 7) |
| opWide | input | 1 | 1: operand is a full 16-bit value; 0: 15-bit, sign-extended |
| operand | input | 16 | Operand value |
| acc | output | 16 | Accumulator, UC in bit 15, SG in bit 14 |
| storeVal | output | 15 | Sign-corrected value of the last store |
| ovf | output | 1 | Accumulator holds an overflow |
| done | output | 1 | Operation complete pulse |
| skip | output | 1 | Skip-next-instruction pulse |
| extraCycle | output | 1 | Store needed an extra cycle |

## Verification
The register and the flag pulses of an ordinary operation change at the edge that samples `start`. The bench compares them in the low phase that follows. A store with overflow moves the accumulator and raises all three pulses one edge later. The bench's behavioural model keeps a pending-correction state so that its expectations land in that cycle. The model is updated at each rising edge, and outputs are compared against it at every falling edge, so no result is sampled before its register has loaded.

// File: rtl/oc_accum_pkg.sv
package oc_accum_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_LOADNEG = 3'd1,
    OP_ADD     = 3'd2,
    OP_SUB     = 3'd3,
    OP_AND     = 3'd4,
    OP_STORE   = 3'd5,
    OP_OVSKIP  = 3'd6,
    OP_IDLE    = 3'd7
  } acc_op_e;

  typedef enum logic [2:0] {
    SRC_OPER  = 3'd0,
    SRC_NEGOP = 3'd1,
    SRC_SUM   = 3'd2,
    SRC_AND   = 3'd3,
    SRC_FIX   = 3'd4
  } acc_src_e;

  typedef struct packed {
    logic     loadAcc;
    acc_src_e accSrc;
    logic     negOperand;
    logic     loadStore;
  } acc_ctl_t;

endpackage

// File: rtl/oc_ones_adder.sv
module oc_ones_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] rawSum;

  always_comb begin
    rawSum = {1'b0, a} + {1'b0, b};
    // end-around carry: a carry out of the top bit re-enters at bit 0
    sum = rawSum[W-1:0] + {{(W-1){1'b0}}, rawSum[W]};
  end
endmodule

// File: rtl/oc_accum_dp.sv
module oc_accum_dp
  import oc_accum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  acc_ctl_t       ctl,
  input  logic           opWide,
  input  logic [W-1:0]   operand,
  output logic [W-1:0]   acc,
  output logic [W-2:0]   storeVal,
  output logic           ovf
);
  localparam int MEM_W = W - 1;

  logic [W-1:0] extOper;
  logic [W-1:0] addend;
  logic [W-1:0] sumVal;
  logic [W-1:0] fixVal;
  logic [W-1:0] accNext;
  logic [MEM_W-1:0] corrected;

  always_comb begin
    extOper = opWide ? operand : {operand[MEM_W-1], operand[MEM_W-1:0]};
    addend  = ctl.negOperand ? ~extOper : extOper;
  end

  oc_ones_adder #(.W(W)) adder_i (
    .a   (acc),
    .b   (addend),
    .sum (sumVal)
  );

  always_comb begin
    fixVal    = acc[W-1] ? {{(W-1){1'b1}}, 1'b0} : {{(W-1){1'b0}}, 1'b1};
    corrected = {acc[W-1], acc[W-3:0]};
    unique case (ctl.accSrc)
      SRC_OPER:  accNext = extOper;
      SRC_NEGOP: accNext = ~extOper;
      SRC_SUM:   accNext = sumVal;
      SRC_AND:   accNext = acc & extOper;
      SRC_FIX:   accNext = fixVal;
      default:   accNext = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      storeVal <= '0;
    end else begin
      if (ctl.loadAcc)   acc      <= accNext;
      if (ctl.loadStore) storeVal <= corrected;
    end
  end

  assign ovf = acc[W-1] ^ acc[W-2];

  // R10, R8: no load strobe means the register keeps its value
  a_r10_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loadAcc |=> $stable(acc));

  // R9: the overflow replacement never leaves an overflow behind
  a_r9_fix_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadAcc && ctl.accSrc == SRC_FIX) |=> !ovf);

  // R8: a store never disturbs the accumulator in the same cycle
  a_r8_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadStore && !ctl.loadAcc) |=> $stable(acc));
endmodule

// File: rtl/oc_accum_ctrl.sv
module oc_accum_ctrl
  import oc_accum_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic [2:0] opCode,
  input  logic     ovf,
  output acc_ctl_t ctl,
  output logic     done,
  output logic     skip,
  output logic     extraCycle
);
  typedef enum logic {ST_IDLE, ST_FIX} ctl_state_e;

  ctl_state_e state, stateNext;
  logic doneNext, skipNext, extraNext;
  acc_op_e op;

  assign op = acc_op_e'(opCode);

  always_comb begin
    ctl        = '{loadAcc: 1'b0, accSrc: SRC_OPER, negOperand: 1'b0, loadStore: 1'b0};
    stateNext  = state;
    doneNext   = 1'b0;
    skipNext   = 1'b0;
    extraNext  = 1'b0;
    if (state == ST_FIX) begin
      ctl.loadAcc = 1'b1;
      ctl.accSrc  = SRC_FIX;
      doneNext    = 1'b1;
      skipNext    = 1'b1;
      extraNext   = 1'b1;
      stateNext   = ST_IDLE;
    end else if (start) begin
      unique case (op)
        OP_LOAD: begin
          ctl.loadAcc = 1'b1; ctl.accSrc = SRC_OPER; doneNext = 1'b1;
        end
        OP_LOADNEG: begin
          ctl.loadAcc = 1'b1; ctl.accSrc = SRC_NEGOP; doneNext = 1'b1;
        end
        OP_ADD: begin
          ctl.loadAcc = 1'b1; ctl.accSrc = SRC_SUM; doneNext = 1'b1;
        end
        OP_SUB: begin
          ctl.loadAcc = 1'b1; ctl.accSrc = SRC_SUM; ctl.negOperand = 1'b1;
          doneNext = 1'b1;
        end
        OP_AND: begin
          ctl.loadAcc = 1'b1; ctl.accSrc = SRC_AND; doneNext = 1'b1;
        end
        OP_STORE: begin
          ctl.loadStore = 1'b1;
          if (ovf) stateNext = ST_FIX;
          else     doneNext  = 1'b1;
        end
        OP_OVSKIP: begin
          doneNext = 1'b1; skipNext = ovf;
        end
        default: doneNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      skip       <= 1'b0;
      extraCycle <= 1'b0;
    end else begin
      state      <= stateNext;
      done       <= doneNext;
      skip       <= skipNext;
      extraCycle <= extraNext;
    end
  end

  // R9: an extra cycle always comes with a skip and a completion
  a_r9_extra_with_skip: assert property (@(posedge clk) disable iff (!rst_n)
    extraCycle |-> (skip && done));

  // R11: a skip is only reported together with completion
  a_r11_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done);

  // R11: the correction state lasts one cycle and then completes
  a_r11_fix_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |=> (state == ST_IDLE && done && extraCycle));

  // R9: a store that sees overflow enters the correction state
  a_r9_store_ovf_enters_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && op == OP_STORE && ovf) |=> (state == ST_FIX && !done));
endmodule

// File: rtl/oc_accum_top.sv
module oc_accum_top
  import oc_accum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   opCode,
  input  logic         opWide,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic [W-2:0] storeVal,
  output logic         ovf,
  output logic         done,
  output logic         skip,
  output logic         extraCycle
);
  acc_ctl_t ctl;

  oc_accum_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opCode     (opCode),
    .ovf        (ovf),
    .ctl        (ctl),
    .done       (done),
    .skip       (skip),
    .extraCycle (extraCycle)
  );

  oc_accum_dp #(.W(W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .opWide   (opWide),
    .operand  (operand),
    .acc      (acc),
    .storeVal (storeVal),
    .ovf      (ovf)
  );
endmodule

// File: tb/oc_accum_tb.sv
module oc_accum_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opCode = 3'd7;
  logic        opWide = 1'b0;
  logic [15:0] operand = 16'd0;
  logic [15:0] acc;
  logic [14:0] storeVal;
  logic        ovf, done, skip, extraCycle;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;

  // reference model state
  int    mAcc = 0, mStore = 0;
  bit    mDone = 0, mSkip = 0, mExtra = 0, mFixPend = 0;
  string mTag = "R1";

  always #10 clk = ~clk;

  oc_accum_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opCode(opCode), .opWide(opWide),
    .operand(operand), .acc(acc), .storeVal(storeVal), .ovf(ovf), .done(done),
    .skip(skip), .extraCycle(extraCycle)
  );

  function automatic int extend(int v, bit wide);
    if (wide) return v & 16'hFFFF;
    return ((v >> 14) & 1) ? ((v & 16'h7FFF) | 16'h8000) : (v & 16'h7FFF);
  endfunction

  function automatic int ocAdd(int a, int b);
    int s = a + b;
    if (s > 65535) s = s - 65536 + 1;
    return s;
  endfunction

  function automatic bit hasOvf(int v);
    return ((v >> 15) & 1) != ((v >> 14) & 1);
  endfunction

  always @(posedge clk) begin
    int x;
    if (!rst_n) begin
      mAcc = 0; mStore = 0; mDone = 0; mSkip = 0; mExtra = 0; mFixPend = 0; mTag = "R1";
    end else begin
      mDone = 0; mSkip = 0; mExtra = 0;
      if (mFixPend) begin
        mAcc = ((mAcc >> 15) & 1) ? 16'hFFFE : 1;
        mDone = 1; mSkip = 1; mExtra = 1; mFixPend = 0; mTag = "R9";
      end else if (start) begin
        x = extend(operand, opWide);
        mDone = 1;
        case (opCode)
          3'd0: begin mAcc = x; mTag = "R2"; end
          3'd1: begin mAcc = 65535 - x; mTag = "R3"; end
          3'd2: begin mAcc = ocAdd(mAcc, x); mTag = "R4"; end
          3'd3: begin mAcc = ocAdd(mAcc, 65535 - x); mTag = "R6"; end
          3'd4: begin mAcc = mAcc & x; mTag = "R7"; end
          3'd5: begin
            mStore = (((mAcc >> 15) & 1) << 14) | (mAcc & 16'h3FFF);
            if (hasOvf(mAcc)) begin mFixPend = 1; mDone = 0; mTag = "R9"; end
            else mTag = "R8";
          end
          3'd6: begin mSkip = hasOvf(mAcc); mTag = "R10"; end
          default: mTag = "R11";
        endcase
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0o expected %0o", mTag, what, act, exp);
    end
  endtask

  // compare every cycle in the low phase (R12 timing)
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("acc", int'(acc), mAcc);
      cmp("storeVal", int'(storeVal), mStore);
      cmp("ovf R5", int'(ovf), int'(hasOvf(mAcc)));
      cmp("done R11", int'(done), int'(mDone));
      cmp("skip", int'(skip), int'(mSkip));
      cmp("extraCycle", int'(extraCycle), int'(mExtra));
    end
  end

  task automatic doOp(int code, int val, bit wide);
    @(negedge clk);
    start = 1'b1; opCode = code[2:0]; operand = val[15:0]; opWide = wide;
    @(negedge clk);
    start = 1'b0; opCode = 3'd7;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    // R1: reset state
    vectors++;
    if (acc !== 16'd0 || storeVal !== 15'd0 || done || skip || extraCycle) begin
      misses++;
      $display("FAIL R1 reset: actual acc %0o store %0o expected 0", acc, storeVal);
    end
    @(negedge clk) rst_n = 1'b1;
    // R2: narrow and wide load
    doOp(0, 16'o037777, 0);
    doOp(0, 16'o040001, 0);
    doOp(0, 16'o140000, 1);
    // R3: negated load, -0
    doOp(1, 0, 0);
    doOp(1, 16'o012345, 0);
    // R4: x + -x = -0
    doOp(0, 5, 0);
    doOp(2, 16'o077772, 0);
    // R5, R10, R9: positive overflow then skip then store
    doOp(0, 16'o037777, 0);
    doOp(2, 1, 0);
    doOp(6, 0, 0);
    doOp(5, 0, 0);
    idle(2);
    // R9: negative overflow store with start during correction (R11)
    doOp(0, 16'o040000, 0);
    doOp(2, 16'o177776, 1);
    @(negedge clk);
    start = 1'b1; opCode = 3'd5;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0; opCode = 3'd7;
    // R8: store without overflow, R10 without overflow
    doOp(0, 16'o012345, 0);
    doOp(5, 0, 0);
    doOp(6, 0, 0);
    // R6, R7
    doOp(3, 16'o000007, 0);
    doOp(0, 16'o177770, 1);
    doOp(4, 16'o052525, 0);
    doOp(7, 16'o000123, 0);
    // mixed patterns, back-to-back
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 3) != 0);
      opCode = 3'($urandom_range(0, 7));
      opWide = 1'($urandom_range(0, 1));
      operand = 16'($urandom());
    end
    @(negedge clk) start = 1'b0;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule